// File: doc/BRIEF.md
# Hardware Cursor Overlay

The block places a 32 by 32 two-colour pointer image over a stream of display pixels. Each incoming pixel carries its raster column, raster line and base colour. The block returns either that base colour or one of two overlay colours. The two overlay colours come in on plain input pins, because the palette that holds them lives outside this block. The image is held as two bit-planes. A mask plane decides where the pointer is opaque. A colour plane then picks which of the two overlay colours is shown at each opaque pixel.

Software programs the pointer through a 32-bit word register bus. The pointer position, the mask rows and the colour rows are written into a pending copy. That copy moves into the active copy only in a cycle where `vsync` is high, so a frame never shows a half-updated pointer. A separate control word sits on the same bus and takes effect at once.

The pixel side is a one-stage valid/ready pipeline. An input pixel is accepted when `px_in_valid` and `px_in_ready` are both high. `px_in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `px_out_valid` is high and `px_out_ready` is low, the output holds every field.

Top module: `curov_top`

## Requirements
- R1: After reset, the active and pending pointer coordinates are both 0xF000 and both planes are all zero. No pixel is overlaid, `px_out_valid` is 0 and `reg_rdata` is 0.
- R2: Register writes are decoded only when address bits 1:0 are zero. A write to 0x8FC stores X from data bits 31:16 and Y from data bits 15:0. A write to 0x900+4*r stores mask row r, and a write to 0x980+4*r stores colour row r, for r from 0 to 31.
- R3: Position, mask and colour writes reach the active copy only in a cycle with `vsync` high. A pixel accepted in that same cycle, or in any earlier cycle, still uses the previous active values.
- R4: Where the mask bit is 0, the output is the base colour with `px_out_src`=0. Where the mask bit is 1 and the colour bit is 1, the output is `ovl_col_hi` with `px_out_src`=3. Where the mask bit is 1 and the colour bit is 0, the output is `ovl_col_lo` with `px_out_src`=2.
- R5: Column X+k of the pointer uses bit 31-k of its row, so bit 31 is the leftmost pixel.
- R6: The overlay applies only on lines y with Y <= y < Y+32. Row y-Y is used.
- R7: The overlay applies only to columns x with X <= x < X+32 and x < `disp_width`. When X >= `disp_width`, no pixel is overlaid.
- R8: A read of 0x818 returns, one cycle after the strobe, the last value written there with bit 25 forced to 1. A read of any other address returns 0. In a cycle after no read, `reg_rdata` is 0. Writes to 0x818 take effect at once.
- R9: An accepted pixel appears on the output one cycle later. `px_in_ready` = !`px_out_valid` || `px_out_ready`. While stalled, the output fields hold stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| vsync | input | 1 | Frame boundary; commits pending pointer state |
| disp_width | input | 16 | Visible width in pixels |
| ovl_col_lo | input | PW | Overlay colour for colour bit 0 |
| ovl_col_hi | input | PW | Overlay colour for colour bit 1 |
| px_in_valid | input | 1 | Input pixel valid |
| px_in_ready | output | 1 | Input pixel accepted when high with valid |
| px_in_x | input | 16 | Raster column of the input pixel |
| px_in_y | input | 16 | Raster line of the input pixel |
| px_in_base | input | PW | Base colour of the input pixel |
| px_out_valid | output | 1 | Output pixel valid |
| px_out_ready | input | 1 | Downstream accepts the output pixel |
| px_out_pix | output | PW | Output colour |
| px_out_src | output | 2 | 0 base, 2 low overlay colour, 3 high overlay colour |

## Verification
The hardest case to reach is a pixel accepted in the very cycle that `vsync` commits new pointer state. That pixel must still see the old pointer, while the next one sees the new pointer. The stimulus places pending writes and then pushes pixels inside the new window both before and across the commit. It also randomly throttles `px_out_ready`, so that some of those pixels sit stalled in the output register while the commit happens. Clipping at the right edge and full suppression are reached by parking the pointer near, and then beyond, a narrowed `disp_width`.

// File: rtl/curov_pkg.sv
package curov_pkg;
  localparam int ROWS  = 32;
  localparam int COLS  = 32;
  localparam int RIDX  = $clog2(ROWS);
  localparam int CW    = 16;
  localparam int AW    = 12;

  typedef logic [ROWS-1:0][COLS-1:0] plane_t;

  typedef enum logic [1:0] {
    SRC_BASE = 2'd0,
    SRC_LO   = 2'd2,
    SRC_HI   = 2'd3
  } src_e;

  localparam logic [AW-1:0] A_MISC = 12'h818;
  localparam logic [AW-1:0] A_POS  = 12'h8FC;
  localparam logic [AW-1:0] A_MASK = 12'h900;
  localparam logic [AW-1:0] A_CBIT = 12'h980;
  localparam logic [CW-1:0] PARK   = 16'hF000;
  localparam int            FORCED_BIT = 25;
endpackage

// File: rtl/curov_regs.sv
module curov_regs
  import curov_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          vsync,
  output logic [31:0]   rdata,
  output logic [CW-1:0] act_x,
  output logic [CW-1:0] act_y,
  output plane_t        act_mask,
  output plane_t        act_cbit
);
  localparam int BLK = $clog2(ROWS) + 2;

  logic [CW-1:0] pend_x, pend_y;
  plane_t        pend_mask, pend_cbit;
  logic [31:0]   misc_q;
  logic          aligned, sel_pos, sel_mask, sel_cbit, sel_misc;
  logic [RIDX-1:0] row;

  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    row      = addr[BLK-1:2];
    sel_pos  = aligned && (addr == A_POS);
    sel_misc = aligned && (addr == A_MISC);
    sel_mask = aligned && (addr[AW-1:BLK] == A_MASK[AW-1:BLK]);
    sel_cbit = aligned && (addr[AW-1:BLK] == A_CBIT[AW-1:BLK]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_x    <= PARK;
      pend_y    <= PARK;
      pend_mask <= '0;
      pend_cbit <= '0;
      misc_q    <= '0;
    end else if (wr) begin
      if (sel_pos) begin
        pend_x <= wdata[31:16];
        pend_y <= wdata[15:0];
      end
      if (sel_mask) pend_mask[row] <= wdata;
      if (sel_cbit) pend_cbit[row] <= wdata;
      if (sel_misc) misc_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_x    <= PARK;
      act_y    <= PARK;
      act_mask <= '0;
      act_cbit <= '0;
    end else if (vsync) begin
      act_x    <= pend_x;
      act_y    <= pend_y;
      act_mask <= pend_mask;
      act_cbit <= pend_cbit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd && sel_misc) begin
      rdata <= misc_q | (32'd1 << FORCED_BIT);
    end else begin
      rdata <= '0;
    end
  end
endmodule

// File: rtl/curov_hit.sv
module curov_hit
  import curov_pkg::*;
(
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] cx,
  input  logic [CW-1:0] cy,
  input  plane_t        mask,
  input  plane_t        cbit,
  output src_e          src
);
  logic [CW:0]      dx, dy;
  logic             in_row, in_col, on_screen;
  logic [COLS-1:0]  mrow, crow;
  logic [RIDX-1:0]  bitpos;

  always_comb begin
    dx        = {1'b0, x} - {1'b0, cx};
    dy        = {1'b0, y} - {1'b0, cy};
    in_row    = !dy[CW] && (dy[CW-1:RIDX] == '0);
    in_col    = !dx[CW] && (dx[CW-1:RIDX] == '0);
    on_screen = (cx < width) && (x < width);
    mrow      = mask[dy[RIDX-1:0]];
    crow      = cbit[dy[RIDX-1:0]];
    bitpos    = ~dx[RIDX-1:0];
    src       = SRC_BASE;
    if (in_row && in_col && on_screen && mrow[bitpos]) begin
      src = crow[bitpos] ? SRC_HI : SRC_LO;
    end
  end
endmodule

// File: rtl/curov_pipe.sv
module curov_pipe
  import curov_pkg::*;
#(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] base,
  input  logic [PW-1:0] col_lo,
  input  logic [PW-1:0] col_hi,
  input  src_e          src,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_pix,
  output logic [1:0]    out_src
);
  logic [PW-1:0] pick;

  always_comb begin
    in_ready = !out_valid || out_ready;
    unique case (src)
      SRC_HI:  pick = col_hi;
      SRC_LO:  pick = col_lo;
      default: pick = base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_src   <= SRC_BASE;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pix <= pick;
        out_src <= src;
      end
    end
  end
endmodule

// File: rtl/curov_top.sv
module curov_top
  import curov_pkg::*;
#(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [11:0]   reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          vsync,
  input  logic [15:0]   disp_width,
  input  logic [PW-1:0] ovl_col_lo,
  input  logic [PW-1:0] ovl_col_hi,
  input  logic          px_in_valid,
  output logic          px_in_ready,
  input  logic [15:0]   px_in_x,
  input  logic [15:0]   px_in_y,
  input  logic [PW-1:0] px_in_base,
  output logic          px_out_valid,
  input  logic          px_out_ready,
  output logic [PW-1:0] px_out_pix,
  output logic [1:0]    px_out_src
);
  logic [CW-1:0] act_x, act_y;
  plane_t        act_mask, act_cbit;
  src_e          hit_src;

  curov_regs regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .vsync(vsync), .rdata(reg_rdata),
    .act_x(act_x), .act_y(act_y), .act_mask(act_mask), .act_cbit(act_cbit)
  );

  curov_hit hit_i (
    .x(px_in_x), .y(px_in_y), .width(disp_width), .cx(act_x), .cy(act_y),
    .mask(act_mask), .cbit(act_cbit), .src(hit_src)
  );

  curov_pipe #(.PW(PW)) pipe_i (
    .clk(clk), .rst_n(rst_n), .in_valid(px_in_valid), .in_ready(px_in_ready),
    .base(px_in_base), .col_lo(ovl_col_lo), .col_hi(ovl_col_hi), .src(hit_src),
    .out_valid(px_out_valid), .out_ready(px_out_ready),
    .out_pix(px_out_pix), .out_src(px_out_src)
  );
endmodule

// File: rtl/curov_chk.sv
module curov_chk #(
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_rd,
  input logic [11:0]   reg_addr,
  input logic [31:0]   reg_rdata,
  input logic [PW-1:0] ovl_col_lo,
  input logic [PW-1:0] ovl_col_hi,
  input logic          px_in_valid,
  input logic          px_in_ready,
  input logic          px_out_valid,
  input logic          px_out_ready,
  input logic [PW-1:0] px_out_pix,
  input logic [1:0]    px_out_src
);
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (px_out_valid && !px_out_ready) |=> (px_out_valid && $stable(px_out_pix) && $stable(px_out_src)));

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (px_in_valid && px_in_ready) |=> px_out_valid);

  a_r4_src_code: assert property (@(posedge clk) disable iff (!rst_n)
    px_out_valid |-> (px_out_src != 2'd1));

  a_r4_hi_colour: assert property (@(posedge clk) disable iff (!rst_n)
    (px_in_valid && px_in_ready) |=> ((px_out_src == 2'd3) -> (px_out_pix == $past(ovl_col_hi))));

  a_r4_lo_colour: assert property (@(posedge clk) disable iff (!rst_n)
    (px_in_valid && px_in_ready) |=> ((px_out_src == 2'd2) -> (px_out_pix == $past(ovl_col_lo))));

  a_r8_quiet_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == 32'd0));

  a_r8_forced_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 12'h818) |=> reg_rdata[25]);
endmodule

bind curov_top curov_chk #(.PW(PW)) chk_i (.*);

// File: tb/curov_tb.sv
`timescale 1ns/1ps
module curov_top_tb_top;
  localparam int PW = 24;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, vsync = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [15:0] disp_width = 16'd1024;
  logic [PW-1:0] ovl_col_lo = 24'h1111AA, ovl_col_hi = 24'hEE5533;
  logic px_in_valid = 0, px_in_ready;
  logic [15:0] px_in_x = 0, px_in_y = 0;
  logic [PW-1:0] px_in_base = 0;
  logic px_out_valid, px_out_ready = 1;
  logic [PW-1:0] px_out_pix;
  logic [1:0] px_out_src;

  always #5 clk = ~clk;

  curov_top #(.PW(PW)) dut_i (.*);

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit stall_mode = 0, acc_now = 0, done = 0;

  // behavioural reference state
  int pnd_x, pnd_y, act_x, act_y, misc_v;
  logic [31:0] pnd_m[32], pnd_c[32], act_m[32], act_c[32];
  logic [PW+1:0] exp_q[$];
  bit rd_pend = 0;
  logic [31:0] rd_exp = 0;

  function automatic logic [PW+1:0] model_px(int x, int y, int w, logic [PW-1:0] base);
    int dx, dy;
    logic m, c;
    if (act_x < w && x < w && y >= act_y && y < act_y + 32 && x >= act_x && x < act_x + 32) begin
      dx = x - act_x; dy = y - act_y;
      m = act_m[dy][31 - dx];
      c = act_c[dy][31 - dx];
      if (m) return c ? {2'd3, ovl_col_hi} : {2'd2, ovl_col_lo};
    end
    return {2'd0, base};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    pnd_x = 16'hF000; pnd_y = 16'hF000; act_x = 16'hF000; act_y = 16'hF000; misc_v = 0;
    for (int r = 0; r < 32; r++) begin pnd_m[r] = 0; pnd_c[r] = 0; act_m[r] = 0; act_c[r] = 0; end
  endtask

  always @(negedge clk) out_ready_drive: px_out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;

  // compare on every clock
  always @(negedge clk) begin
    #1;
    acc_now = 0;
    if (!rst_n) begin
      exp_q.delete(); rd_pend = 0; model_reset();
    end else begin
      check("R9 out_valid", px_out_valid, exp_q.size() != 0);
      check("R9 in_ready", px_in_ready, exp_q.size() == 0 || px_out_ready);
      if (exp_q.size() != 0 && px_out_valid)
        check({cur_req, " pixel"}, {px_out_src, px_out_pix}, exp_q[0]);
      check("R8 rdata", reg_rdata, rd_pend ? rd_exp : 32'd0);
      if (px_out_valid && px_out_ready && exp_q.size() != 0) void'(exp_q.pop_front());
      if (px_in_valid && px_in_ready) begin
        acc_now = 1;
        exp_q.push_back(model_px(px_in_x, px_in_y, disp_width, px_in_base));
      end
      rd_pend = reg_rd;
      rd_exp  = (reg_rd && reg_addr == 12'h818) ? (misc_v | 32'h0200_0000) : 32'd0;
      if (vsync) begin // R3: commit before this cycle's write
        act_x = pnd_x; act_y = pnd_y;
        for (int r = 0; r < 32; r++) begin act_m[r] = pnd_m[r]; act_c[r] = pnd_c[r]; end
      end
      if (reg_wr && reg_addr[1:0] == 0) begin // R2 decode
        if (reg_addr == 12'h8FC) begin pnd_x = reg_wdata[31:16]; pnd_y = reg_wdata[15:0]; end
        if (reg_addr >= 12'h900 && reg_addr < 12'h980) pnd_m[(reg_addr - 12'h900) >> 2] = reg_wdata;
        if (reg_addr >= 12'h980 && reg_addr < 12'hA00) pnd_c[(reg_addr - 12'h980) >> 2] = reg_wdata;
        if (reg_addr == 12'h818) misc_v = reg_wdata;
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d, bit vs = 0);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d; vsync = vs;
    @(posedge clk); #1 reg_wr = 0; vsync = 0;
  endtask

  task automatic rd(logic [11:0] a);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic frame();
    @(negedge clk); vsync = 1;
    @(posedge clk); #1 vsync = 0;
  endtask

  task automatic px(int x, int y, bit vs = 0);
    @(negedge clk);
    px_in_valid = 1; px_in_x = x; px_in_y = y; px_in_base = {x[11:0], y[11:0]} ^ 24'h5A5A5A;
    vsync = vs;
    forever begin
      @(posedge clk);
      if (acc_now) break;
    end
    #1 px_in_valid = 0; vsync = 0;
  endtask

  task automatic scan(int x0, int x1, int y0, int y1);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) px(x, y);
  endtask

  task automatic load_shape(int seed);
    for (int r = 0; r < 32; r++) begin
      wr(12'h900 + 12'(4 * r), {$urandom} ^ 32'(seed * 33 + r));
      wr(12'h980 + 12'(4 * r), {$urandom});
    end
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    @(negedge clk); #2;
    check("R1 out_valid", px_out_valid, 0);
    check("R1 rdata", reg_rdata, 0);
    cur_req = "R1"; scan(0, 7, 0, 3);
    frame(); scan(0, 3, 0, 1);

    // R2, R3: pending writes invisible until commit
    cur_req = "R3";
    wr(12'h8FC, {16'd8, 16'd4});
    load_shape(1);
    scan(6, 14, 3, 6);
    rd(12'h8FC); rd(12'h904);
    // commit in the same cycle a pixel is accepted: that pixel sees old state
    px(10, 5, 1);
    cur_req = "R4/R5/R6";
    stall_mode = 1;
    scan(0, 45, 2, 38);

    // R8: control word
    cur_req = "R8";
    wr(12'h818, 32'h0000_1234); rd(12'h818);
    wr(12'h818, 32'hFFFF_0000); rd(12'h818);
    wr(12'h819, 32'h0000_0000); rd(12'h818);
    rd(12'h81C);

    // R2: misaligned write ignored, write with vsync lands after commit
    cur_req = "R2";
    wr(12'h8FE, {16'd0, 16'd0});
    wr(12'h8FC, {16'd20, 16'd40}, 1);
    scan(6, 14, 3, 6);
    frame();
    scan(18, 30, 38, 42);

    // R7: clip at right edge, then full suppression
    cur_req = "R7";
    load_shape(7);
    wr(12'h8FC, {16'd1010, 16'd100});
    frame();
    scan(1004, 1023, 99, 132);
    @(negedge clk); disp_width = 16'd1016;
    scan(1008, 1023, 100, 104);
    @(negedge clk); disp_width = 16'd1000;
    scan(995, 1023, 100, 103);
    @(negedge clk); disp_width = 16'd1010;
    scan(1008, 1012, 100, 102);

    // R4: colour inputs changed
    cur_req = "R4";
    @(negedge clk); disp_width = 16'd1024; ovl_col_lo = 24'h00C0DE; ovl_col_hi = 24'hBEEF00;
    scan(1010, 1023, 110, 112);

    stall_mode = 0;
    repeat (4) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule